// File: doc/BRIEF.md
# Stacked-Die Response Serializer

This block models the test-response path of a stack of dies that share one tester channel in time-division fashion. Each die holds one serializer flip-flop, so the chain has exactly as many stages as the stack has dies. In the time-division mode, a capture strobe makes every stage take its own die's wrapper response on one test-clock edge. After that, the chain moves the captured bits one die per clock toward the bottom die, which drives the single stack output. In the same mode every die hands the stack's test input straight up to the die above it, so all dies receive the same serial stream.

When the mode bit is cleared, the stack falls back to the conventional daisy chain. Each die above the bottom takes its test input from the response of the die below it. The stack output is the top die's response, carried down through a bypass mux in each die. The serializer stages keep their contents untouched while the stack is in this mode.

Top module: `stack_resp_serializer`

## Requirements
- R1: A low `rst_n` sampled on a rising clock edge clears every serializer stage to 0 (synchronous, active-low). Right after reset in time-division mode, `stack_tdo` is 0.
- R2: With `tdm_en`=1 and `cap_strobe`=1, stage k loads `die_resp[k]` on the rising edge. Stage 0 is the bottom die, and `stack_tdo` then shows the captured `die_resp[0]`.
- R3: With `tdm_en`=1 and `cap_strobe`=0, every stage k takes the value of stage k+1 on each edge. In time-division mode `stack_tdo` equals stage 0, so a captured word leaves bottom die first, one bit per clock.
- R4: While shifting, the top stage loads 0. After a capture and N shifts, `stack_tdo` is 0.
- R5: With `tdm_en`=0, `stack_tdo` equals `die_resp[N-1]` (the top die's response) in the same cycle.
- R6: With `tdm_en`=0, the stages keep their values whatever `cap_strobe` and `die_resp` do. Returning to `tdm_en`=1 resumes shifting from the held state.
- R7: With `tdm_en`=1, every bit of `die_tdi` equals `stack_tdi`.
- R8: With `tdm_en`=0, `die_tdi[0]` equals `stack_tdi` and `die_tdi[k]` equals `die_resp[k-1]` for k ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdm_en | input | 1 | 1 = time-division path, 0 = conventional daisy chain |
| cap_strobe | input | 1 | Parallel capture of all die responses into the chain |
| stack_tdi | input | 1 | Serial test input entering the bottom die |
| die_resp | input | NUM_DIES | Wrapper response of each die, bit 0 = bottom die |
| die_tdi | output | NUM_DIES | Test input delivered to each die's wrapper |
| stack_tdo | output | 1 | Serial test output leaving the bottom die |

## Verification
On every cycle, the assertions check these relations: the capture, the one-place shift with a zero filled in at the top, the freeze of the stages in conventional mode, and the port-level routing of both the upward and downward paths. Some properties only show across several cycles and a mode change. These are the order in which a captured word leaves the stack, and the bits held through a conventional-mode interval being shifted out unchanged afterwards. The bench shows them by comparing `stack_tdo` against its own model of the chain, over directed sequences and random mode and strobe patterns.

// File: rtl/srz_pkg.sv
// Shared types for the stacked-die response serializer.
// Assumes: a single mode bit selects between the two path configurations.
package srz_pkg;

    typedef enum logic {
        MODE_CHAIN = 1'b0,
        MODE_TDM   = 1'b1
    } srz_mode_e;

endpackage

// File: rtl/srz_die_stage.sv
// One die's serializer slice: a single flip-flop plus the downward output mux.
// Time-division mode: capture the die response on the strobe, otherwise take
// the bit from the die above. Conventional mode: hold the flop and pass the
// bypass path from above straight down.
// Assumes: the top die ties from_above to 0 and down_in to its own response.
module srz_die_stage
    import srz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tdm_en,
    input  logic cap_strobe,
    input  logic resp_bit,
    input  logic from_above,
    input  logic down_in,
    output logic stage_q,
    output logic down_out
);

    srz_mode_e mode;
    logic      stage_d;

    // Decode the mode bit into the shared enum.
    assign mode = srz_mode_e'(tdm_en);

    // Next-state choice: capture, shift or hold.
    always_comb begin
        stage_d = stage_q;
        if (mode == MODE_TDM) begin
            if (cap_strobe) begin
                stage_d = resp_bit;
            end else begin
                stage_d = from_above;
            end
        end
    end

    // The serializer flop itself, synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Downward output: serialized bit or conventional bypass.
    always_comb begin
        down_out = (mode == MODE_TDM) ? stage_q : down_in;
    end

endmodule

// File: rtl/srz_up_route.sv
// One die's upward test-input mux.
// Time-division mode: the die receives the stack test input unchanged.
// Conventional mode: it receives the response of the die below (or the stack
// input for the bottom die, which the parent passes in as below_bit).
// Assumes: purely combinational, no state.
module srz_up_route
    import srz_pkg::*;
(
    input  logic tdm_en,
    input  logic stack_tdi,
    input  logic below_bit,
    output logic tdi_out
);

    srz_mode_e mode;

    // Decode the mode bit into the shared enum.
    assign mode = srz_mode_e'(tdm_en);

    // Select forwarded stack input or daisy-chained lower response.
    always_comb begin
        tdi_out = (mode == MODE_TDM) ? stack_tdi : below_bit;
    end

endmodule

// File: rtl/stack_resp_serializer.sv
// Top of the stacked-die response serializer: one slice per die, stitched
// into a chain that shifts toward the bottom die's output.
// Assumes: NUM_DIES >= 2, bit 0 of every per-die vector is the bottom die.
module stack_resp_serializer #(
    parameter int NUM_DIES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tdm_en,
    input  logic                cap_strobe,
    input  logic                stack_tdi,
    input  logic [NUM_DIES-1:0] die_resp,
    output logic [NUM_DIES-1:0] die_tdi,
    output logic                stack_tdo
);

    localparam int TOP = NUM_DIES - 1;

    logic [NUM_DIES-1:0] stage_q;
    logic [NUM_DIES-1:0] down_path;
    logic [NUM_DIES-1:0] above_bit;
    logic [NUM_DIES-1:0] bypass_in;
    logic [NUM_DIES-1:0] below_bit;

    for (genvar k = 0; k < NUM_DIES; k++) begin : g_die
        if (k == TOP) begin : g_top
            // Top die: zero fill while shifting, own response feeds the bypass.
            assign above_bit[k] = 1'b0;
            assign bypass_in[k] = die_resp[k];
        end else begin : g_mid
            // Lower dies: take the bit and the bypass from the die above.
            assign above_bit[k] = stage_q[k+1];
            assign bypass_in[k] = down_path[k+1];
        end

        if (k == 0) begin : g_bot
            // Bottom die: conventional test input is the stack input.
            assign below_bit[k] = stack_tdi;
        end else begin : g_up
            // Upper dies: conventional test input is the lower die's response.
            assign below_bit[k] = die_resp[k-1];
        end

        srz_die_stage u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .tdm_en     (tdm_en),
            .cap_strobe (cap_strobe),
            .resp_bit   (die_resp[k]),
            .from_above (above_bit[k]),
            .down_in    (bypass_in[k]),
            .stage_q    (stage_q[k]),
            .down_out   (down_path[k])
        );

        srz_up_route u_route (
            .tdm_en    (tdm_en),
            .stack_tdi (stack_tdi),
            .below_bit (below_bit[k]),
            .tdi_out   (die_tdi[k])
        );
    end

    // The bottom die's downward path is the stack output.
    assign stack_tdo = down_path[0];

endmodule

// File: rtl/stack_resp_serializer_chk.sv
// Property checker for the stacked-die response serializer, bound to the top.
// Assumes: the stage vector is visible in the top's scope as stage_q.
module stack_resp_serializer_chk #(
    parameter int NUM_DIES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tdm_en,
    input logic                cap_strobe,
    input logic                stack_tdi,
    input logic [NUM_DIES-1:0] die_resp,
    input logic [NUM_DIES-1:0] die_tdi,
    input logic                stack_tdo,
    input logic [NUM_DIES-1:0] stage_q
);

    logic past_valid = 1'b0;

    // Marks that at least one clock edge has been seen.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        (past_valid && rst_n && !$past(rst_n)) |-> (stage_q == '0));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && tdm_en && cap_strobe)) |-> (stage_q == $past(die_resp)));

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && tdm_en && !cap_strobe))
            |-> (stage_q[NUM_DIES-2:0] == $past(stage_q[NUM_DIES-1:1])));

    p_tdm_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tdm_en |-> (stack_tdo == stage_q[0]));

    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && tdm_en && !cap_strobe)) |-> !stage_q[NUM_DIES-1]);

    p_bypass_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tdm_en |-> (stack_tdo == die_resp[NUM_DIES-1]));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && !tdm_en)) |-> $stable(stage_q));

    p_fanout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tdm_en |-> (die_tdi == {NUM_DIES{stack_tdi}}));

    p_daisy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tdm_en |-> ((die_tdi[0] == stack_tdi)
                     && (die_tdi[NUM_DIES-1:1] == die_resp[NUM_DIES-2:0])));

endmodule

bind stack_resp_serializer stack_resp_serializer_chk #(.NUM_DIES(NUM_DIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tdm_en     (tdm_en),
    .cap_strobe (cap_strobe),
    .stack_tdi  (stack_tdi),
    .die_resp   (die_resp),
    .die_tdi    (die_tdi),
    .stack_tdo  (stack_tdo),
    .stage_q    (stage_q)
);

// File: tb/stack_resp_serializer_bench.sv
// Self-checking bench: directed corner cases followed by seeded random cycles,
// all compared against a bench-side model of the chain.
module stack_resp_serializer_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tdm_en = 1'b1;
    logic         cap_strobe = 1'b0;
    logic         stack_tdi = 1'b0;
    logic [N-1:0] die_resp = '0;
    logic [N-1:0] die_tdi;
    logic         stack_tdo;

    logic [N-1:0] model = '0;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    stack_resp_serializer #(.NUM_DIES(N)) u_stack_resp_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdm_en     (tdm_en),
        .cap_strobe (cap_strobe),
        .stack_tdi  (stack_tdi),
        .die_resp   (die_resp),
        .die_tdi    (die_tdi),
        .stack_tdo  (stack_tdo)
    );

    // 125 MHz test clock.
    always #4 clk = ~clk;

    // Expected stack output from the requirements (R3 and R5).
    function automatic logic exp_tdo(logic m, logic [N-1:0] st, logic [N-1:0] resp);
        return m ? st[0] : resp[N-1];
    endfunction

    // Expected per-die test inputs from the requirements (R7 and R8).
    function automatic logic [N-1:0] exp_tdi(logic m, logic tdi, logic [N-1:0] resp);
        return m ? {N{tdi}} : {resp[N-2:0], tdi};
    endfunction

    // Next model state (R1 to R4 and R6).
    function automatic logic [N-1:0] next_model(logic rn, logic m, logic ld,
                                                logic [N-1:0] st, logic [N-1:0] resp);
        if (!rn) return '0;
        if (!m)  return st;
        if (ld)  return resp;
        return {1'b0, st[N-1:1]};
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stack_tdo=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: die_tdi=%b expected %b", tag, act, exp);
        end
    endtask

    // Inputs are already set after a negedge; check outputs, then clock once.
    task automatic cycle(string tag);
        #1;
        check_bit(tag, stack_tdo, exp_tdo(tdm_en, model, die_resp));
        check_vec(tag, die_tdi, exp_tdi(tdm_en, stack_tdi, die_resp));
        @(posedge clk);
        model = next_model(rst_n, tdm_en, cap_strobe, model, die_resp);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with capture requested must still clear the chain.
        die_resp = '1; cap_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model = '0;
        cycle("R1");
        rst_n = 1'b1; cap_strobe = 1'b0;
        cycle("R1");
        check_bit("R1 after release", stack_tdo, 1'b0);

        // R2/R3/R4: capture 1011 (bottom bit 1), shift out bottom first, zero fill.
        die_resp = 4'b1011; cap_strobe = 1'b1;
        cycle("R2 capture");
        check_bit("R2 bottom bit", stack_tdo, 1'b1);
        cap_strobe = 1'b0; die_resp = '0;
        cycle("R3 shift1"); check_bit("R3 bit1", stack_tdo, 1'b1);
        cycle("R3 shift2"); check_bit("R3 bit2", stack_tdo, 1'b0);
        cycle("R3 shift3"); check_bit("R3 bit3", stack_tdo, 1'b1);
        cycle("R4 shift4"); check_bit("R4 zero fill", stack_tdo, 1'b0);

        // R6/R5/R8: capture 0110, shift once, freeze in conventional mode.
        die_resp = 4'b0110; cap_strobe = 1'b1;
        cycle("R2 capture2");
        cap_strobe = 1'b0;
        cycle("R3 pre-hold");
        tdm_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cap_strobe = 1'($urandom);
            die_resp = N'($urandom);
            stack_tdi = 1'($urandom);
            cycle("R5/R8 conventional");
        end
        die_resp = 4'b1000;
        #1 check_bit("R5 top response", stack_tdo, 1'b1);
        tdm_en = 1'b1; cap_strobe = 1'b0; die_resp = '0;
        #1 check_bit("R6 held bit1", stack_tdo, 1'b1);
        cycle("R6 resume");
        check_bit("R6 held bit2", stack_tdo, 1'b1);
        cycle("R6 resume");
        check_bit("R6 held bit3", stack_tdo, 1'b0);

        // R7: fan-out of stack input in time-division mode.
        stack_tdi = 1'b1; die_resp = 4'b0101;
        #1 check_vec("R7 fanout", die_tdi, 4'b1111);
        cycle("R7");

        // Random mix of all requirements against the model.
        for (int i = 0; i < 3000; i++) begin
            rst_n      = ($urandom % 64) != 0;
            tdm_en     = ($urandom % 4) != 0;
            cap_strobe = ($urandom % 5) == 0;
            stack_tdi  = 1'($urandom);
            die_resp   = N'($urandom);
            cycle("R1-R8 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule